// File: doc/BRIEF.md
# Top octave tone generator

The block derives a full keyboard of square-wave note signals from one master clock. Twelve independent counters each divide the clock by a fixed ratio picked so that their outputs sit close to the twelve equal-tempered semitones of the highest octave. Beneath each of these top-octave lines, a chain of toggle stages halves the frequency again and again to give the lower octaves. With the default five octaves this makes 60 note lines. An optional extra line gives the C one octave above the lowest top note, for 61 outputs in all.

The master clock is nominally 2 MHz, so one clock period is 0.5 us. Every output is a plain logic-level square wave, meant for later mixing or keying. A synchronous reset puts every counter and stage at zero. While the enable input is low, the whole generator holds its state. All timing below is counted in enabled clock edges, meaning rising edges of `clk_i` at which `rst_i` is low and `en_i` is high.

The outputs are indexed as octave * 12 + semitone. Octave 0 is the lowest octave and octave 4 is the top octave. Semitone 0 is C and semitone 11 is B.

Top module: `tone_gen_top`

## Requirements
- R1: While `rst_i` is sampled high, every bit of `note_o` is 0 from the following clock edge onward.
- R2: An edge at which `en_i` is low (reset low) leaves every bit of `note_o` unchanged.
- R3: The top-octave line of semitone s, at `note_o[48+s]`, rises once every N enabled edges. N is 239, 225, 213, 201, 190, 179, 169, 159, 150, 142, 134, 127 for s = 0 (C) up to s = 11 (B).
- R4: Each top-octave line stays high for ceil(N/2) enabled edges of each period, and low for the rest.
- R5: The line `note_o[o*12+s]` with o < 4 rises once every N * 2^(4-o) enabled edges, which is exactly twice the period of the octave above it.
- R6: A line in octave o <= 2 changes only at the clock edge where line (o+1)*12+s rises. A line in octave 3 changes only at the edge that ends the top-octave counter's cycle.
- R7: When HIGH_C is 1, `note_o[60]` is the high C. It is produced by one toggle stage that switches at four points of the C counter's cycle. Its rising edges are alternately 120 and 119 enabled edges apart, so two consecutive intervals sum to 239.
- R8: When HIGH_C is 0, `note_o` is 60 bits wide. Those 60 bits behave exactly like bits 59..0 of the HIGH_C = 1 build under the same stimulus.
- R9: Take the first enabled edge after reset is released. After that edge, all twelve top-octave lines are 1, and every lower-octave line and the high C are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, nominally 2 MHz |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable; low freezes all state |
| note_o | output | 12*OCTAVES+HIGH_C | Square-wave note lines, indexed octave*12+semitone; high C on the top bit when HIGH_C is 1 |

## Verification
The bench builds two copies with OCTAVES = 5. One has HIGH_C = 1 and gives the 61-line generator with the quarter-point high C. The other has HIGH_C = 0 and gives the 60-line variant, which is compared bit for bit against the first. Five octaves make the lowest periods as long as 3824 enabled edges. This lets the bench check doubling down the whole chain, and the hold behaviour, under a randomly gated enable. A reset in mid-run checks that the phase restarts cleanly.

// File: rtl/tog_pkg.sv
package tog_pkg;
  localparam int SEMIS = 12;

  // division ratio of one top-octave semitone counter, s = 0 is C
  function automatic int tog_ratio(input int s);
    case (s)
      0:  return 239;
      1:  return 225;
      2:  return 213;
      3:  return 201;
      4:  return 190;
      5:  return 179;
      6:  return 169;
      7:  return 159;
      8:  return 150;
      9:  return 142;
      10: return 134;
      default: return 127;
    endcase
  endfunction

  // number of counts the square wave spends high: ceil(n/2)
  function automatic int tog_high_len(input int n);
    return (n + 1) / 2;
  endfunction

  // quarter points used for the octave-up line derived from one counter
  function automatic int tog_q1(input int n);
    return (tog_high_len(n) + 1) / 2;
  endfunction

  function automatic int tog_q3(input int n);
    return tog_high_len(n) + (n - tog_high_len(n) + 1) / 2;
  endfunction
endpackage

// File: rtl/tog_divider.sv
module tog_divider
  import tog_pkg::*;
#(
  parameter int RATIO      = 239,
  parameter bit QUARTER_EN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic sq_o,
  output logic wrap_o,
  output logic quarter_o
);
  localparam int CW = $clog2(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
  localparam logic [CW-1:0] HI   = CW'(tog_high_len(RATIO));

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          at_last;
  logic          sq_q;

  assign at_last = (cnt_q == LAST);
  assign cnt_nxt = at_last ? '0 : cnt_q + CW'(1);
  assign wrap_o  = en_i && at_last;
  assign sq_o    = sq_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (en_i) begin
      cnt_q <= cnt_nxt;
      sq_q  <= (cnt_nxt != '0) && (cnt_nxt <= HI);
    end
  end

  generate
    if (QUARTER_EN) begin : g_quarter
      localparam logic [CW-1:0] Q1M = CW'(tog_q1(RATIO) - 1);
      localparam logic [CW-1:0] HIM = CW'(tog_high_len(RATIO) - 1);
      localparam logic [CW-1:0] Q3M = CW'(tog_q3(RATIO) - 1);
      assign quarter_o = en_i && (at_last || cnt_q == Q1M ||
                                  cnt_q == HIM || cnt_q == Q3M);
    end else begin : g_no_quarter
      assign quarter_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tog_chain.sv
module tog_chain #(
  parameter int STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  output logic [STAGES-1:0] q_o
);
  // step[k] marks the edge at which stage k toggles; a stage passes a step
  // down only when it is about to rise
  logic [STAGES:0]   step;
  logic [STAGES-1:0] q_q;

  assign step[0] = tick_i;
  assign q_o     = q_q;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      assign step[k+1] = step[k] && !q_q[k];
      always_ff @(posedge clk_i) begin
        if (rst_i)        q_q[k] <= 1'b0;
        else if (step[k]) q_q[k] <= ~q_q[k];
      end
    end
  endgenerate
endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
  import tog_pkg::*;
#(
  parameter int OCTAVES   = 5,
  parameter bit HIGH_C    = 1'b1,
  localparam int NUM_NOTES = SEMIS * OCTAVES + (HIGH_C ? 1 : 0)
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 en_i,
  output logic [NUM_NOTES-1:0] note_o
);
  localparam int LOWER = OCTAVES - 1;
  localparam int TOPB  = LOWER * SEMIS;

  logic [SEMIS-1:0] wrap_evt;
  logic [SEMIS-1:0] top_sq;
  logic [SEMIS-1:0] quarter_vec;
  logic [LOWER-1:0] chain_q [SEMIS];

  generate
    for (genvar s = 0; s < SEMIS; s++) begin : g_note
      tog_divider #(
        .RATIO      (tog_ratio(s)),
        .QUARTER_EN (HIGH_C && (s == 0))
      ) u_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .sq_o      (top_sq[s]),
        .wrap_o    (wrap_evt[s]),
        .quarter_o (quarter_vec[s])
      );

      tog_chain #(.STAGES(LOWER)) u_chain (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (wrap_evt[s]),
        .q_o    (chain_q[s])
      );

      assign note_o[TOPB + s] = top_sq[s];
      for (genvar k = 0; k < LOWER; k++) begin : g_oct
        assign note_o[(LOWER - 1 - k) * SEMIS + s] = chain_q[s][k];
      end
    end

    if (HIGH_C) begin : g_high_c
      logic hic_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)             hic_q <= 1'b0;
        else if (|quarter_vec) hic_q <= ~hic_q;
      end
      assign note_o[NUM_NOTES-1] = hic_q;
    end
  endgenerate
endmodule

// File: rtl/tog_checker.sv
module tog_checker #(
  parameter int OCTAVES   = 5,
  parameter bit HIGH_C    = 1'b1,
  localparam int NUM_NOTES = 12 * OCTAVES + (HIGH_C ? 1 : 0)
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic                 en_i,
  input logic [NUM_NOTES-1:0] note_i,
  input logic [11:0]          wrap_i
);
  logic rst_seen_q;
  always_ff @(posedge clk_i) rst_seen_q <= rst_i;

  // R1: one edge after reset is sampled, every line is low
  always @(posedge clk_i) begin
    if (rst_seen_q === 1'b1)
      p_reset_clears_r1: assert (note_i == '0);
  end

  // R2: a disabled edge holds all lines
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(note_i));

  generate
    for (genvar s = 0; s < 12; s++) begin : g_s
      // R6: octave just below the top moves only on its counter's wrap
      p_chain_head_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(note_i[(OCTAVES - 2) * 12 + s]) |-> $past(wrap_i[s]));
      for (genvar o = 0; o < OCTAVES - 2; o++) begin : g_o
        // R6: a lower stage moves only when the stage above rises
        p_chain_step_r6: assert property (@(posedge clk_i) disable iff (rst_i)
          !$stable(note_i[o * 12 + s]) |-> $rose(note_i[(o + 1) * 12 + s]));
      end
    end
  endgenerate
endmodule

bind tone_gen_top tog_checker #(.OCTAVES(OCTAVES), .HIGH_C(HIGH_C)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .en_i   (en_i),
  .note_i (note_o),
  .wrap_i (wrap_evt)
);

// File: tb/sim_tone_gen_top.sv
`timescale 1ns/1ps
module sim_tone_gen_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [60:0] n0;
  logic [59:0] n1;

  int n_chk  = 0;
  int n_fail = 0;
  int ecnt   = 0;
  bit en_s   = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tone_gen_top #(.OCTAVES(5), .HIGH_C(1'b1)) u0 (
    .clk_i(clk), .rst_i(rst), .en_i(en), .note_o(n0));
  tone_gen_top #(.OCTAVES(5), .HIGH_C(1'b0)) u1 (
    .clk_i(clk), .rst_i(rst), .en_i(en), .note_o(n1));

  function automatic int bratio(input int s);
    int t[12] = '{239, 225, 213, 201, 190, 179, 169, 159, 150, 142, 134, 127};
    return t[s];
  endfunction

  function automatic int exp_period(input int idx);
    return bratio(idx % 12) * (1 << (4 - idx / 12));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // count enabled edges
  always @(posedge clk) begin
    en_s = en && !rst;
    if (en_s) ecnt++;
  end

  // monitor: periods, duty, chain ordering, hold, variant match
  logic [60:0] prev = '0;
  int last_rise [61];
  int last_iv   [61];
  int nrise     [61];

  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        for (int i = 0; i < 61; i++) begin
          nrise[i] = 0;
          last_iv[i] = 0;
        end
      end else begin
        if (!en_s) chk(n0 == prev, "R2 hold", longint'(n0), longint'(prev));
        chk(n1 == n0[59:0], "R8 variant match", longint'(n1), longint'(n0[59:0]));
        for (int i = 0; i < 61; i++) begin
          bit rise, fall;
          rise = n0[i] && !prev[i];
          fall = !n0[i] && prev[i];
          if (i < 36 && n0[i] != prev[i])
            chk(n0[i+12] && !prev[i+12], "R6 chain step", i, i + 12);
          if (rise) begin
            if (nrise[i] > 0) begin
              int iv;
              iv = ecnt - last_rise[i];
              if (i == 60) begin
                chk(iv == 119 || iv == 120, "R7 high C interval", iv, 120);
                if (last_iv[i] != 0)
                  chk(iv + last_iv[i] == 239, "R7 high C pair", iv + last_iv[i], 239);
              end else if (i >= 48) begin
                chk(iv == exp_period(i), "R3 top period", iv, exp_period(i));
              end else begin
                chk(iv == exp_period(i), "R5 lower period", iv, exp_period(i));
              end
              last_iv[i] = iv;
            end
            last_rise[i] = ecnt;
            nrise[i]++;
          end
          if (fall && i >= 48 && i < 60 && nrise[i] > 0)
            chk(ecnt - last_rise[i] == (bratio(i - 48) + 1) / 2, "R4 top duty",
                ecnt - last_rise[i], (bratio(i - 48) + 1) / 2);
        end
      end
      prev = n0;
    end
  end

  task automatic summary;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset(input int cyc);
    @(posedge clk); #1 rst = 1'b1;
    repeat (cyc) @(posedge clk);
    @(negedge clk);
    chk(n0 == '0, "R1 reset u0", longint'(n0), 0);
    chk(n1 == '0, "R1 reset u1", longint'(n1), 0);
  endtask

  task automatic release_and_check;
    @(posedge clk); #1 begin rst = 1'b0; en = 1'b1; end
    @(posedge clk); @(negedge clk);
    chk(n0[59:48] == 12'hFFF, "R9 top high", longint'(n0[59:48]), 12'hFFF);
    chk(n0[47:0] == '0, "R9 lower low", longint'(n0[47:0]), 0);
    chk(n0[60] == 1'b0, "R9 high C low", longint'(n0[60]), 0);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd1357));
    chk($bits(n1) == 60, "R8 width", $bits(n1), 60);
    chk($bits(n0) == 61, "R8 width full", $bits(n0), 61);
    do_reset(5);
    release_and_check();
    repeat (20000) @(posedge clk);
    // directed long idle stretch
    #1 en = 1'b0;
    repeat (500) @(posedge clk);
    #1 en = 1'b1;
    // random enable gating
    for (int c = 0; c < 30000; c++) begin
      @(posedge clk); #1 en = ($urandom % 4) != 0;
    end
    // reset in mid-run, then restart
    do_reset(3);
    release_and_check();
    repeat (10000) @(posedge clk);
    @(negedge clk);
    summary();
  end
endmodule